// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. Each channel turns a qualified trigger edge into an output pulse whose length is a count of clock cycles, taken from a per-channel width input at the moment of the trigger. Two trigger inputs with opposite polarity feed each channel. One fires on its rising edge while the other is high. The other fires on its falling edge while the first is low. Either input can therefore be tied off, so the channel fires on a rising edge or on a falling edge. Both trigger inputs are asynchronous and pass through a two-flop synchronizer before edge detection.

A trigger that arrives during a pulse reloads the counter, so the pulse ends a full width after the last trigger. A per-channel mode bit turns this off, which gives a non-retriggerable one-shot. An active-low clear input cuts the output low at once and blocks triggers while it is held. When the clear is released, the channel holds off triggers for a short, parameterised recovery interval, and a flag shows that interval. A parameter sets the number of channels (default two), and the channels do not interact.

Top module: `oneshot_array`

## Requirements
- R1: After the system reset `rst_n` is released, every channel shows `q_o`=0, `qn_o`=1 and `rec_o`=0.
- R2: A rising edge on `a_i` while `b_i` is high and `clr_n_i` is high is a valid trigger. If `a_i` changes just before clock edge k, `q_o` rises right after edge k+2 and stays low after edges k and k+1.
- R3: After a trigger, with no further trigger, `q_o` stays high for exactly W clock cycles, where W is the value of `width_i` for that channel. A width of 0 acts as 1.
- R4: A falling edge on `b_i` while `a_i` is low and `clr_n_i` is high is a valid trigger, with the same latency and length as R2 and R3.
- R5: These edges start no pulse: a rising `a_i` while `b_i` is low, a falling `b_i` while `a_i` is high, a falling `a_i`, and a rising `b_i`.
- R6: When `nretrig_i`=0, a valid trigger during a pulse reloads the counter from the current `width_i`, so `q_o` stays high until W cycles after the last trigger. This holds when the retrigger lands in the final cycle of the pulse.
- R7: While `clr_n_i` is low, `q_o` is 0 and `qn_o` is 1 with no clock delay, even partway through a pulse.
- R8: Trigger edges that occur while `clr_n_i` is low start no pulse.
- R9: `rec_o` is high while `clr_n_i` is low and for REC_CYCLES (default 2) clock cycles after its release. A trigger evaluated while `rec_o` is high is dropped, and triggers after that are accepted.
- R10: When `nretrig_i`=1, triggers during a pulse are ignored, so the pulse lasts W cycles from the first trigger.
- R11: Channels are independent. Stimulus on one channel leaves the outputs of the others unchanged, and overlapping pulses on two channels each keep their own width.
- R12: `qn_o` is always the complement of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| a_i | input | NUM_CH | Rising-edge trigger inputs, asynchronous |
| b_i | input | NUM_CH | Falling-edge trigger inputs, asynchronous |
| clr_n_i | input | NUM_CH | Active-low per-channel clear, synchronous to clk |
| nretrig_i | input | NUM_CH | 1 selects non-retriggerable mode |
| width_i | input | NUM_CH x WIDTH_W | Pulse length in cycles, sampled at each trigger |
| q_o | output | NUM_CH | Pulse outputs |
| qn_o | output | NUM_CH | Complement of q_o |
| rec_o | output | NUM_CH | Clear-recovery flag |

## Verification
A retrigger and the expiry of a pulse can fall on the same clock edge: a new trigger can be registered in the very cycle where the counter reaches its last count. The bench provokes this by placing a second rising edge on `a_i` five cycles after the first, with a six-cycle width. The reload then coincides with the final count. In retrigger mode the pulse must run on for the newly sampled width with no low gap, giving eight high samples. In non-retriggerable mode the pulse must end on time, giving exactly six.

// File: rtl/oneshot_pkg.sv
// Package: oneshot_pkg
// Shared types and helpers for the digital one-shot channels.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package oneshot_pkg;

    // Synchronized view of one trigger input: current level and edge flags.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_view_t;

    // Widths of zero are treated as a single-cycle pulse.
    function automatic int unsigned eff_width(input int unsigned w);
        return (w == 0) ? 1 : w;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
// Module: oneshot_sync
// Two-flop synchronizer followed by one history flop for edge detection.
// Assumes din is asynchronous; RST_VAL chooses the reset level so that no
// false edge of the polarity that matters appears when reset is released.
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    output edge_view_t view
);

    logic [2:0] stage;

    // Shift the input through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= {3{RST_VAL}};
        end else begin
            stage <= {stage[1:0], din};
        end
    end

    // Derive level and edges from the second and third flops.
    always_comb begin
        view.lvl  = stage[1];
        view.rise = stage[1] & ~stage[2];
        view.fall = ~stage[1] & stage[2];
    end

endmodule

// File: rtl/oneshot_gate.sv
// Module: oneshot_gate
// Trigger qualification and clear-recovery hold-off for one channel.
// Assumes clr_n is synchronous to clk. Produces a single-cycle fire strobe.
module oneshot_gate
    import oneshot_pkg::*;
#(
    parameter int REC_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  edge_view_t av,
    input  edge_view_t bv,
    input  logic       clr_n,
    input  logic       nretrig,
    input  logic       busy,
    output logic       fire,
    output logic       rec
);

    localparam int RW = (REC_CYCLES < 1) ? 1 : $clog2(REC_CYCLES + 1);
    localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYCLES);

    logic [RW-1:0] rec_cnt;
    logic          edge_ok;

    // Hold the recovery count full while cleared, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt <= '0;
        end else if (!clr_n) begin
            rec_cnt <= REC_LOAD;
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    // Qualify an edge on either input by the level of the other one.
    always_comb begin
        edge_ok = (av.rise & bv.lvl) | (bv.fall & ~av.lvl);
        rec     = (rec_cnt != '0);
        fire    = edge_ok & clr_n & ~rec & ~(busy & nretrig);
    end

    // R9: recovery counts down one step per cycle once clear is released.
    p_rec_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && rec_cnt != '0) |=> (rec_cnt == $past(rec_cnt) - 1'b1));

    // R9: nothing is fired during the hold-off.
    p_rec_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec |-> !fire);

    // R8: no trigger passes while clear is low.
    p_clr_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !fire);

endmodule

// File: rtl/oneshot_timer.sv
// Module: oneshot_timer
// Pulse register and down-counter for one channel. A fire strobe sets the
// pulse and loads the width; clear drops both. Assumes fire is one cycle.
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse
);

    logic [WIDTH_W-1:0] cnt;
    logic [WIDTH_W-1:0] load_val;

    // Width to load, with zero promoted to one cycle.
    always_comb begin
        load_val = WIDTH_W'(eff_width(int'(width)));
    end

    // Set, reload, count down and expire the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (!clr_n) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (fire) begin
            pulse <= 1'b1;
            cnt   <= load_val;
        end else if (pulse) begin
            if (cnt <= WIDTH_W'(1)) begin
                pulse <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R2: an accepted trigger makes the pulse high on the next edge.
    p_fire_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr_n) |=> pulse);

    // R7: clear empties the timer on the following edge.
    p_clr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (!pulse && cnt == '0));

    // R3: a running pulse always holds a non-zero remaining count.
    p_busy_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt != '0));

    // R3: without a trigger the count falls by exactly one.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !fire && clr_n && cnt > WIDTH_W'(1))
        |=> (pulse && cnt == $past(cnt) - 1'b1));

    // R3: the last count ends the pulse.
    p_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !fire && clr_n && cnt == WIDTH_W'(1)) |=> !pulse);

endmodule

// File: rtl/oneshot_channel.sv
// Module: oneshot_channel
// One complete one-shot: two synchronizers, the trigger gate and the timer.
// Assumes clr_n is synchronous; the output gating by clear is done at top.
module oneshot_channel
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W    = 8,
    parameter int REC_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a,
    input  logic               b,
    input  logic               clr_n,
    input  logic               nretrig,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse,
    output logic               rec
);

    edge_view_t av;
    edge_view_t bv;
    logic       fire;

    // A resets high so release cannot fake a rising edge.
    oneshot_sync #(.RST_VAL(1'b1)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(a), .view(av)
    );

    // B resets low so release cannot fake a falling edge.
    oneshot_sync #(.RST_VAL(1'b0)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(b), .view(bv)
    );

    oneshot_gate #(.REC_CYCLES(REC_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .av(av), .bv(bv), .clr_n(clr_n),
        .nretrig(nretrig), .busy(pulse), .fire(fire), .rec(rec)
    );

    oneshot_timer #(.WIDTH_W(WIDTH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr_n(clr_n),
        .width(width), .pulse(pulse)
    );

    // R10: in non-retriggerable mode a running pulse is never refired.
    p_nretrig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && nretrig) |-> !fire);

endmodule

// File: rtl/oneshot_array.sv
// Module: oneshot_array
// Top of the digital one-shot: NUM_CH independent channels. Clear gates
// each output combinationally so that it takes effect without a clock.
// Assumes clr_n_i, nretrig_i and width_i are synchronous to clk.
module oneshot_array
    import oneshot_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int WIDTH_W    = 8,
    parameter int REC_CYCLES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CH-1:0]               a_i,
    input  logic [NUM_CH-1:0]               b_i,
    input  logic [NUM_CH-1:0]               clr_n_i,
    input  logic [NUM_CH-1:0]               nretrig_i,
    input  logic [NUM_CH-1:0][WIDTH_W-1:0]  width_i,
    output logic [NUM_CH-1:0]               q_o,
    output logic [NUM_CH-1:0]               qn_o,
    output logic [NUM_CH-1:0]               rec_o
);

    logic [NUM_CH-1:0] pulse;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        oneshot_channel #(.WIDTH_W(WIDTH_W), .REC_CYCLES(REC_CYCLES)) u_chan (
            .clk(clk), .rst_n(rst_n), .a(a_i[ch]), .b(b_i[ch]),
            .clr_n(clr_n_i[ch]), .nretrig(nretrig_i[ch]),
            .width(width_i[ch]), .pulse(pulse[ch]), .rec(rec_o[ch])
        );
    end

    // Drive the complementary outputs, cut at once by clear.
    always_comb begin
        q_o  = pulse & clr_n_i;
        qn_o = ~q_o;
    end

endmodule

// File: tb/oneshot_array_bench.sv
module oneshot_array_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int WW  = 8;
    localparam int NVEC = 11;

    // Columns: channel, kind, width, expected high cycles.
    // Kinds: 0 A rise (B high), 1 B fall (A low), 2 A rise with B low,
    // 3 B fall with A high, 4 A fall, 5 B rise.
    localparam int VEC [NVEC][4] = '{
        '{0, 0,   5,   5},
        '{0, 1,   7,   7},
        '{1, 0,   3,   3},
        '{1, 1,   1,   1},
        '{0, 0,   0,   1},
        '{0, 2,   5,   0},
        '{0, 3,   5,   0},
        '{0, 4,   5,   0},
        '{1, 5,   5,   0},
        '{1, 0,  12,  12},
        '{0, 0, 255, 255}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] a, b, clr_n, nr;
    logic [NCH-1:0][WW-1:0] wd;
    logic [NCH-1:0] q, qn, rec;

    int n_tests = 0;
    int n_fail  = 0;
    int qn_bad  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oneshot_array #(.NUM_CH(NCH), .WIDTH_W(WW), .REC_CYCLES(2)) u_oneshot_array (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .clr_n_i(clr_n),
        .nretrig_i(nr), .width_i(wd), .q_o(q), .qn_o(qn), .rec_o(rec)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and let combinational outputs settle.
    task automatic nxt();
        @(negedge clk);
        #1;
        if (qn !== ~q) qn_bad++;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) nxt();
    endtask

    task automatic count_high(input int n, output int c0, output int c1);
        c0 = 0;
        c1 = 0;
        for (int i = 0; i < n; i++) begin
            nxt();
            if (q[0]) c0++;
            if (q[1]) c1++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0, c1, mine, other, ch, win;
        rst_n = 1'b0;
        a = '0; b = '1; clr_n = '1; nr = '0; wd = '0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        // R1: reset state
        chk("R1 q", int'(q), 0);
        chk("R1 qn", int'(qn), 3);
        chk("R1 rec", int'(rec), 0);

        // Vector table: R2 R3 R4 R5 R11
        for (int v = 0; v < NVEC; v++) begin
            ch = VEC[v][0];
            wd[ch] = WW'(VEC[v][2]);
            case (VEC[v][1])
                0: begin a[ch] = 1'b0; b[ch] = 1'b1; end
                1: begin a[ch] = 1'b0; b[ch] = 1'b1; end
                2: begin a[ch] = 1'b0; b[ch] = 1'b0; end
                3: begin a[ch] = 1'b1; b[ch] = 1'b1; end
                4: begin a[ch] = 1'b1; b[ch] = 1'b1; end
                default: begin a[ch] = 1'b0; b[ch] = 1'b0; end
            endcase
            wait_n(40);
            case (VEC[v][1])
                0: a[ch] = 1'b1;
                1: b[ch] = 1'b0;
                2: a[ch] = 1'b1;
                3: b[ch] = 1'b0;
                4: a[ch] = 1'b0;
                default: b[ch] = 1'b1;
            endcase
            win = VEC[v][2] + 10;
            count_high(win, c0, c1);
            mine  = (ch == 0) ? c0 : c1;
            other = (ch == 0) ? c1 : c0;
            chk($sformatf("R3/R4/R5 vector %0d pulse length", v), mine, VEC[v][3]);
            chk($sformatf("R11 vector %0d other channel", v), other, 0);
            a[ch] = 1'b0; b[ch] = 1'b1;
            wait_n(40);
        end

        // R2: exact latency from an A rise
        wd[0] = 8'd4;
        a[0] = 1'b1;
        nxt(); chk("R2 low after k", int'(q[0]), 0);
        nxt(); chk("R2 low after k+1", int'(q[0]), 0);
        nxt(); chk("R2 high after k+2", int'(q[0]), 1);
        a[0] = 1'b0;
        wait_n(20);

        // R6: retrigger on the final count, new width sampled
        wd[0] = 8'd6; nr[0] = 1'b0;
        a[0] = 1'b1; c0 = 0;
        for (int i = 1; i <= 20; i++) begin
            nxt();
            if (q[0]) c0++;
            if (i == 3) a[0] = 1'b0;
            if (i == 5) begin a[0] = 1'b1; wd[0] = 8'd3; end
        end
        chk("R6 retrigger length", c0, 8);
        a[0] = 1'b0;
        wait_n(20);

        // R10: same stimulus in non-retriggerable mode
        wd[0] = 8'd6; nr[0] = 1'b1;
        a[0] = 1'b1; c0 = 0;
        for (int i = 1; i <= 20; i++) begin
            nxt();
            if (q[0]) c0++;
            if (i == 3) a[0] = 1'b0;
            if (i == 5) begin a[0] = 1'b1; wd[0] = 8'd3; end
        end
        chk("R10 nonretrigger length", c0, 6);
        a[0] = 1'b0; nr[0] = 1'b0;
        wait_n(20);

        // R7: clear truncates a pulse with no clock delay
        wd[0] = 8'd20;
        a[0] = 1'b1;
        wait_n(6);
        chk("R7 pulse running", int'(q[0]), 1);
        clr_n[0] = 1'b0;
        #1;
        chk("R7 q cut at once", int'(q[0]), 0);
        chk("R7 qn set at once", int'(qn[0]), 1);
        // R8: trigger edges while cleared
        a[0] = 1'b0;
        wait_n(4);
        chk("R9 rec while cleared", int'(rec[0]), 1);
        a[0] = 1'b1;
        c0 = 0;
        for (int i = 0; i < 6; i++) begin nxt(); if (q[0]) c0++; end
        chk("R8 no pulse while cleared", c0, 0);
        a[0] = 1'b0;
        wait_n(6);
        // R9: trigger landing in the recovery window is dropped
        a[0] = 1'b1;
        nxt();
        clr_n[0] = 1'b1;
        nxt(); chk("R9 rec first cycle", int'(rec[0]), 1);
        nxt(); chk("R9 rec cleared", int'(rec[0]), 0);
        count_high(30, c0, c1);
        chk("R9 dropped in recovery", c0, 0);
        a[0] = 1'b0;
        wait_n(6);
        wd[0] = 8'd5;
        a[0] = 1'b1;
        count_high(15, c0, c1);
        chk("R9 accepted after recovery", c0, 5);
        a[0] = 1'b0;
        wait_n(20);

        // R11: overlapping pulses keep their own widths
        wd[0] = 8'd4; wd[1] = 8'd9;
        a = 2'b11;
        count_high(20, c0, c1);
        chk("R11 ch0 overlap", c0, 4);
        chk("R11 ch1 overlap", c1, 9);
        a = 2'b00;
        wait_n(5);

        // R12: complement seen on every sample
        chk("R12 qn mismatches", qn_bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule